// File: doc/BRIEF.md
# Parallel Bit-Slice Lane Collector

This block reads a group of serial sources in one shared pass rather than one source after another. On a start request it raises a freeze output, which tells every source to keep its current sample. It then drives a fixed number of pulses on one shared serial clock. During each high phase it captures all lane inputs in the same cycle, and this set of bits is one slice. Each source shifts its most significant bit out first, so the first slice holds the top bit of every lane.

After the last pulse the freeze output drops. The stored slices are read back one per cycle and turned into one word per lane. The new words reach the output in the same cycle as a one-cycle done pulse, and they stay unchanged until the next transfer completes. The word length is a parameter, so moving from 8-bit to 10-bit samples only adds two more pulses inside the same freeze window. Input pins above the number of lanes in use are ignored, and their word slots read as zero.

Top module: `slice_collector`

## Requirements
- R1: After a synchronous reset, `freeze_en`, `sclk`, `done` and every bit of `lane_words` are 0. A reset during a transfer abandons it.
- R2: A `start_req` seen while idle raises `freeze_en`. `freeze_en` stays high for at least SCLK_LOW clocks before the first rising edge of `sclk`.
- R3: Each transfer drives exactly WORD_BITS pulses on `sclk`. Each pulse is high for SCLK_HIGH clocks, and the gaps between pulses are low for SCLK_LOW clocks.
- R4: `sclk` is never high while `freeze_en` is low. `freeze_en` falls only after the last pulse has ended, with a further SCLK_LOW clocks of low `sclk`.
- R5: All used lanes of `lane_din` are captured on the same clock edge, SAMPLE_DLY+1 clocks after each rising edge of `sclk`, while `sclk` is still high.
- R6: Lane j's word sits in `lane_words[j*WORD_BITS +: WORD_BITS]`. Slice i, counted from 0, supplies bit WORD_BITS-1-i of every word, so the first slice is the MSB.
- R7: Word slots for lanes j >= LANES_USED read 0 whatever those input pins carry.
- R8: `done` is high for exactly one cycle per transfer, and only after `freeze_en` has fallen. `lane_words` takes its new value in the same cycle that `done` rises and changes at no other time.
- R9: A `start_req` that arrives during a transfer is ignored. The transfer keeps its pulse count and data, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin a transfer (accepted only when idle) |
| lane_din | input | LANE_PINS | One serial data bit per source |
| freeze_en | output | 1 | Holds every source's sample while high |
| sclk | output | 1 | Shared serial clock to all sources |
| done | output | 1 | One-cycle pulse when the new words are valid |
| lane_words | output | LANE_PINS*WORD_BITS | Rebuilt word per lane, lane 0 in the low bits |

## Verification
The bench's sources change their data only on falling edges of `sclk`. A design that sampled at the wrong time, or assembled the slices LSB-first, would return shifted or bit-reversed words. Patterns that are all ones, and mixed patterns with the unused pins driven high, expose a design that leaks those pins into the zeroed slots. A start request sent during a transfer catches a design that restarts, stretches the pulse train or fires a second done. A reset during a transfer must leave the clock and freeze outputs low and clear the words.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_READ,
    ST_WAIT,
    ST_PUB
  } slc_state_t;
endpackage

// File: rtl/slc_seq.sv
module slc_seq #(
  parameter int WORD_BITS  = 10,
  parameter int SCLK_HIGH  = 3,
  parameter int SCLK_LOW   = 3,
  parameter int SAMPLE_DLY = 1,
  parameter int AW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  output logic          freeze_en,
  output logic          sclk,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] idx,
  output logic          publish,
  output logic          done
);
  import slc_pkg::*;

  localparam int PH_MAX = (SCLK_HIGH > SCLK_LOW) ? SCLK_HIGH : SCLK_LOW;
  localparam int CW     = $clog2(PH_MAX + 1);
  localparam logic [CW-1:0] HI_LAST = CW'(SCLK_HIGH - 1);
  localparam logic [CW-1:0] LO_LAST = CW'(SCLK_LOW - 1);
  localparam logic [CW-1:0] SMP_AT  = CW'(SAMPLE_DLY);
  localparam logic [AW-1:0] IDX_END = AW'(WORD_BITS - 1);

  slc_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      freeze_en <= 1'b0;
      sclk      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            freeze_en <= 1'b1;
            cnt       <= '0;
            idx       <= '0;
            state     <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (cnt == LO_LAST) begin
            cnt   <= '0;
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt == HI_LAST) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (idx == IDX_END) begin
              state <= ST_TAIL;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == LO_LAST) begin
            cnt       <= '0;
            freeze_en <= 1'b0;
            idx       <= '0;
            state     <= ST_READ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (idx == IDX_END) state <= ST_WAIT;
          else                idx   <= idx + 1'b1;
        end
        ST_WAIT: state <= ST_PUB;
        ST_PUB: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == ST_HIGH) && (cnt == SMP_AT);
    rd_en   = (state == ST_READ);
    publish = (state == ST_PUB);
  end
endmodule

// File: rtl/slc_slice_ram.sv
module slc_slice_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 10,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/slc_transpose.sv
module slc_transpose #(
  parameter int LANE_PINS  = 8,
  parameter int LANES_USED = 8,
  parameter int WORD_BITS  = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           shift_en,
  input  logic [LANES_USED-1:0]          slice,
  input  logic                           publish,
  output logic [LANE_PINS*WORD_BITS-1:0] words
);
  for (genvar j = 0; j < LANE_PINS; j++) begin : g_lane
    if (j < LANES_USED) begin : g_used
      logic [WORD_BITS-1:0] work;
      logic [WORD_BITS-1:0] held;
      always_ff @(posedge clk) begin
        if (shift_en) work <= {work[WORD_BITS-2:0], slice[j]};
      end
      always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (publish) held <= work;
      end
      assign words[j*WORD_BITS +: WORD_BITS] = held;
    end else begin : g_idle
      assign words[j*WORD_BITS +: WORD_BITS] = '0;
    end
  end
endmodule

// File: rtl/slice_collector.sv
module slice_collector #(
  parameter int LANE_PINS  = 8,
  parameter int LANES_USED = 8,
  parameter int WORD_BITS  = 10,
  parameter int SCLK_HIGH  = 3,
  parameter int SCLK_LOW   = 3,
  parameter int SAMPLE_DLY = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_req,
  input  logic [LANE_PINS-1:0]           lane_din,
  output logic                           freeze_en,
  output logic                           sclk,
  output logic                           done,
  output logic [LANE_PINS*WORD_BITS-1:0] lane_words
);
  localparam int AW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  logic                  wr_en, rd_en, publish, rvalid;
  logic [AW-1:0]         idx;
  logic [LANES_USED-1:0] rd_slice;

  slc_seq #(
    .WORD_BITS (WORD_BITS),
    .SCLK_HIGH (SCLK_HIGH),
    .SCLK_LOW  (SCLK_LOW),
    .SAMPLE_DLY(SAMPLE_DLY),
    .AW        (AW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_req(start_req),
    .freeze_en(freeze_en),
    .sclk     (sclk),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .idx      (idx),
    .publish  (publish),
    .done     (done)
  );

  slc_slice_ram #(
    .WIDTH(LANES_USED),
    .DEPTH(WORD_BITS),
    .AW   (AW)
  ) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .re    (rd_en),
    .addr  (idx),
    .wdata (lane_din[LANES_USED-1:0]),
    .rdata (rd_slice),
    .rvalid(rvalid)
  );

  slc_transpose #(
    .LANE_PINS (LANE_PINS),
    .LANES_USED(LANES_USED),
    .WORD_BITS (WORD_BITS)
  ) u_xpose (
    .clk     (clk),
    .rst     (rst),
    .shift_en(rvalid),
    .slice   (rd_slice),
    .publish (publish),
    .words   (lane_words)
  );
endmodule

// File: rtl/slice_collector_chk.sv
module slice_collector_chk #(
  parameter int LANE_PINS  = 8,
  parameter int LANES_USED = 8,
  parameter int WORD_BITS  = 10
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           freeze_en,
  input logic                           sclk,
  input logic                           done,
  input logic [LANE_PINS*WORD_BITS-1:0] lane_words
);
  localparam int RW = $clog2(WORD_BITS + 2) + 1;

  logic          frz_q, sclk_q;
  logic [RW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q    <= 1'b0;
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      frz_q  <= freeze_en;
      sclk_q <= sclk;
      if (freeze_en && !frz_q)  rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r4_sclk_needs_freeze: assert property (@(posedge clk) disable iff (rst)
    !freeze_en |-> !sclk);

  a_r2_freeze_leads: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $past(freeze_en));

  a_r3_pulse_count: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !freeze_en) |-> (rise_cnt == RW'(WORD_BITS)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_freeze: assert property (@(posedge clk) disable iff (rst)
    done |-> !freeze_en);

  a_r8_words_change_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane_words) |-> done);

  if (LANES_USED < LANE_PINS) begin : g_r7
    a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
      lane_words[LANE_PINS*WORD_BITS-1:LANES_USED*WORD_BITS] == '0);
  end
endmodule

bind slice_collector slice_collector_chk #(
  .LANE_PINS (LANE_PINS),
  .LANES_USED(LANES_USED),
  .WORD_BITS (WORD_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .freeze_en (freeze_en),
  .sclk      (sclk),
  .done      (done),
  .lane_words(lane_words)
);

// File: tb/slice_collector_test.sv
module slice_collector_test;
  localparam int PINS = 8;
  localparam int USED = 6;
  localparam int WB   = 10;
  localparam int HI   = 3;
  localparam int LO   = 3;
  localparam int TW   = PINS * WB;
  localparam int NV   = 4;

  localparam logic [TW-1:0] STIM [NV] = '{
    80'hFFFF_FFFF_FFFF_FFFF_FFFF,
    80'h0000_0000_0000_0000_0000,
    80'hA5C3_0F12_7E81_9B24_C66D,
    80'h0123_4567_89AB_CDEF_0246
  };
  localparam logic [TW-1:0] EXPV [NV] = '{
    80'h0000_0FFF_FFFF_FFFF_FFFF,
    80'h0000_0000_0000_0000_0000,
    80'h0000_0F12_7E81_9B24_C66D,
    80'h0000_0567_89AB_CDEF_0246
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_req = 1'b0;
  logic [PINS-1:0] lane_din = '0;
  logic            freeze_en, sclk, done;
  logic [TW-1:0]   lane_words;

  int n_chk = 0, n_fail = 0;
  int rises = 0, k = 0, hi_run = 0, bad_hi = 0, frz_cyc = 0, lead = 0, done_cnt = 0;
  logic          prev_s = 1'b0;
  logic [WB-1:0] slv [PINS];

  always #2 clk = ~clk;

  slice_collector #(
    .LANE_PINS(PINS), .LANES_USED(USED), .WORD_BITS(WB),
    .SCLK_HIGH(HI), .SCLK_LOW(LO), .SAMPLE_DLY(1)
  ) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .lane_din(lane_din),
    .freeze_en(freeze_en), .sclk(sclk), .done(done), .lane_words(lane_words)
  );

  // Source model: MSB first, data changes only after a falling sclk edge.
  always @(negedge clk) begin
    if (sclk && !prev_s) begin
      rises = rises + 1;
      if (rises == 1) lead = frz_cyc;
    end
    if (sclk) hi_run = hi_run + 1;
    else if (prev_s) begin
      if (hi_run != HI) bad_hi = bad_hi + 1;
      hi_run = 0;
      k = k + 1;
    end
    if (freeze_en) frz_cyc = frz_cyc + 1;
    if (done) done_cnt = done_cnt + 1;
    prev_s = sclk;
    for (int j = 0; j < PINS; j++)
      lane_din[j] = (k < WB) ? slv[j][WB-1-k] : 1'b0;
  end

  task automatic check(input bit ok, input string tag, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_srcs(input logic [TW-1:0] v);
    for (int j = 0; j < PINS; j++) slv[j] = v[j*WB +: WB];
    rises = 0; k = 0; hi_run = 0; bad_hi = 0; frz_cyc = 0; lead = 0; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    check(done, "R8 done timeout", TW'(w), TW'(0));
  endtask

  initial begin
    for (int j = 0; j < PINS; j++) slv[j] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!freeze_en, "R1 freeze after reset", TW'(freeze_en), TW'(0));
    check(!sclk, "R1 sclk after reset", TW'(sclk), TW'(0));
    check(!done, "R1 done after reset", TW'(done), TW'(0));
    check(lane_words == '0, "R1 words after reset", lane_words, '0);

    for (int v = 0; v < NV; v++) begin
      logic [TW-1:0] held;
      load_srcs(STIM[v]);
      pulse_start();
      wait_done();
      held = lane_words;
      check(lane_words == EXPV[v], "R5 R6 R7 words", lane_words, EXPV[v]);
      check(rises == WB, "R3 pulse count", TW'(rises), TW'(WB));
      check(bad_hi == 0, "R3 high width", TW'(bad_hi), TW'(0));
      check(lead >= LO, "R2 freeze lead", TW'(lead), TW'(LO));
      check(!freeze_en, "R4 freeze low at done", TW'(freeze_en), TW'(0));
      @(negedge clk);
      check(!done, "R8 done one cycle", TW'(done), TW'(0));
      repeat (5) @(negedge clk);
      check(lane_words == held, "R8 words held", lane_words, held);
    end

    // R9: start during a transfer is ignored
    load_srcs(STIM[3]);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done();
    check(lane_words == EXPV[3], "R9 words with busy start", lane_words, EXPV[3]);
    check(rises == WB, "R9 pulse count with busy start", TW'(rises), TW'(WB));
    frz_cyc = 0;
    repeat (60) @(negedge clk);
    check(frz_cyc == 0, "R9 no second transfer", TW'(frz_cyc), TW'(0));
    check(done_cnt == 1, "R9 single done", TW'(done_cnt), TW'(1));

    // R1: reset during a transfer
    load_srcs(STIM[0]);
    pulse_start();
    repeat (15) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!freeze_en && !sclk, "R1 outputs low in reset", TW'({freeze_en, sclk}), TW'(0));
    rst = 1'b0;
    load_srcs(STIM[0]);
    repeat (40) @(negedge clk);
    check(lane_words == '0, "R1 words cleared", lane_words, '0);
    check(done_cnt == 0 && !freeze_en, "R1 transfer abandoned", TW'(done_cnt), TW'(0));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule